// File: doc/BRIEF.md
# Board Interrupt Routing Fabric

This block carries level-sensitive interrupt lines from a board into a processor cluster. Each of the 64 board lines is copied, unchanged and at the same index, onto each of four secondary interrupt controller ports. A fixed sparse lookup table also sends twelve of the lower 32 board lines straight to chosen inputs of a 32-line processor-side vector.

The level outputs of the four secondary controllers come back into the block. Controller `n` drives processor input `10+n`. Processor inputs that no source reaches are tied low. When more than one source lands on the same processor input, the sources are ORed. The controllers themselves are outside this block.

A parameter selects an optional output register. When it is enabled, every output path, the secondary ports and the processor vector alike, is delayed by exactly one clock, so all paths stay aligned.

Top module: `irq_route_fabric`

## Requirements
- R1: Secondary port `n` (bits `[n*64 +: 64]` of `sec_port_irq`) equals `board_irq` for every n in 0..3.
- R2: Board lines 32..63 have no effect on any `proc_irq` bit.
- R3: The direct map drives these processor inputs from these board lines:
  - 19→0, 4→1, 5→2, 29→3, 12→4, 13→5
  - 10→6, 20→7, 21→8, 28→9, 17→14, 18→15
- R4: Board lines 0..31 that are not listed in R3 have no effect on any `proc_irq` bit.
- R5: `sec_irq_in[n]` drives `proc_irq[10+n]` for n in 0..3.
- R6: Processor inputs that no source reaches, which are bits 16..31, stay low.
- R7: Sources active at the same time produce the union of their outputs. Several sources that land on one processor input are ORed together.
- R8: With `REG_OUT=1`, every output shows its inputs exactly one clock edge later, with the same latency on all paths.
- R9: While `rst_n` is low at a clock edge, all registered outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| board_irq | input | 64 | Level interrupt lines from the board |
| sec_irq_in | input | 4 | Level outputs of the four secondary controllers |
| sec_port_irq | output | 256 | Fan-out to the four secondary controllers, 64 bits per port |
| proc_irq | output | 32 | Processor-side interrupt vector |

## Verification
The hardest case to reach from the ports is proving that a line has no effect. An unmapped lower line or any upper line must leave all 32 processor bits low. At the same moment, the same line must still appear on all four secondary ports.

The stimulus walks a single one across all 64 board lines and across the four feedback inputs. Each step is scored against an independent table. This isolates every source and catches a wrong, missing or extra route. Random multi-source patterns and an alternating all-ones/all-zeros train then exercise the union behaviour and the one-cycle alignment between the two output groups.

// File: rtl/irq_route_pkg.sv
// Package: irq_route_pkg
// Purpose : constants and constant functions shared by the routing fabric.
// Assumes : the sparse direct table is fixed at design time. A source with
//           no processor destination returns -1.
package irq_route_pkg;

    localparam int MASK_MAX = 64;

    // Destination processor input for a lower board line, -1 if unmapped.
    function automatic int direct_dst(input int src);
        case (src)
            4:       return 1;
            5:       return 2;
            10:      return 6;
            12:      return 4;
            13:      return 5;
            17:      return 14;
            18:      return 15;
            19:      return 0;
            20:      return 7;
            21:      return 8;
            28:      return 9;
            29:      return 3;
            default: return -1;
        endcase
    endfunction

    // Set of processor inputs that at least one source can reach.
    function automatic logic [MASK_MAX-1:0] driven_mask(
        input int n_direct, input int fb_base, input int n_sec, input int n_proc);
        logic [MASK_MAX-1:0] m;
        m = '0;
        for (int i = 0; i < n_direct; i++) begin
            if (direct_dst(i) >= 0 && direct_dst(i) < n_proc) m[direct_dst(i)] = 1'b1;
        end
        for (int n = 0; n < n_sec; n++) begin
            if (fb_base + n < n_proc) m[fb_base + n] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_fanout.sv
// Module : irq_fanout
// Purpose: copies the board vector onto every secondary controller port.
// Assumes: ports are packed side by side, port n at bits [n*W +: W].
module irq_fanout #(
    parameter int W     = 64,
    parameter int PORTS = 4
) (
    input  logic [W-1:0]       lines_in,
    output logic [PORTS*W-1:0] ports_out
);
    // One replica per port, same bit index.
    for (genvar n = 0; n < PORTS; n++) begin : g_port
        assign ports_out[n*W +: W] = lines_in;
    end
endmodule

// File: rtl/irq_direct_map.sv
// Module : irq_direct_map
// Purpose: applies the fixed sparse lookup from lower board lines to the
//          processor vector; unreached outputs are low.
// Assumes: only the first N_DIRECT inputs take part; collisions are ORed.
module irq_direct_map #(
    parameter int N_DIRECT = 32,
    parameter int N_PROC   = 32
) (
    input  logic [N_DIRECT-1:0] lower_in,
    output logic [N_PROC-1:0]   mapped_out
);
    import irq_route_pkg::*;

    // Walk the table and OR each mapped source into its destination.
    always_comb begin
        mapped_out = '0;
        for (int i = 0; i < N_DIRECT; i++) begin
            if (direct_dst(i) >= 0 && direct_dst(i) < N_PROC)
                mapped_out[direct_dst(i)] = mapped_out[direct_dst(i)] | lower_in[i];
        end
    end
endmodule

// File: rtl/irq_fb_merge.sv
// Module : irq_fb_merge
// Purpose: ORs the secondary controller outputs into their reserved slots
//          of the processor vector, on top of the direct map result.
// Assumes: FB_BASE + N_SEC <= N_PROC.
module irq_fb_merge #(
    parameter int N_PROC  = 32,
    parameter int N_SEC   = 4,
    parameter int FB_BASE = 10
) (
    input  logic [N_PROC-1:0] direct_in,
    input  logic [N_SEC-1:0]  fb_in,
    output logic [N_PROC-1:0] merged_out
);
    logic [N_PROC-1:0] fb_placed;

    // Place controller n on slot FB_BASE+n; other slots get nothing.
    for (genvar p = 0; p < N_PROC; p++) begin : g_slot
        if (p >= FB_BASE && p < FB_BASE + N_SEC) begin : g_fb
            assign fb_placed[p] = fb_in[p - FB_BASE];
        end else begin : g_none
            assign fb_placed[p] = 1'b0;
        end
    end

    // Union of both source kinds.
    assign merged_out = direct_in | fb_placed;
endmodule

// File: rtl/irq_out_stage.sv
// Module : irq_out_stage
// Purpose: optional single register on the whole output bundle, so every
//          path sees the same latency (0 or 1 cycle).
// Assumes: synchronous active-low reset clears the register.
module irq_out_stage #(
    parameter int W   = 288,
    parameter bit REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    if (REG) begin : g_reg
        logic primed;
        logic rst_seen;

        // Capture the bundle each cycle, clear in reset.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= d;
        end

        // Track reset history for the checks below.
        always_ff @(posedge clk) begin
            if (!rst_n) primed <= 1'b0;
            else        primed <= 1'b1;
            rst_seen <= !rst_n;
        end

        AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            primed |-> (q == $past(d))); // R8

        // Output must read zero right after a reset edge.
        always_comb begin
            if (rst_seen == 1'b1) begin
                AST_RESET_CLEAR: assert (q == '0); // R9
            end
        end
    end else begin : g_comb
        assign q = d;
    end
endmodule

// File: rtl/irq_route_fabric.sv
// Module : irq_route_fabric
// Purpose: top of the board interrupt router. Fans all board lines out to
//          the secondary controllers, maps selected lower lines to the
//          processor vector, and merges controller feedback into fixed slots.
// Assumes: level-sensitive lines throughout; REG_OUT adds one aligned cycle.
module irq_route_fabric #(
    parameter int N_BOARD  = 64,
    parameter int N_SEC    = 4,
    parameter int N_PROC   = 32,
    parameter int N_DIRECT = 32,
    parameter int FB_BASE  = 10,
    parameter bit REG_OUT  = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_BOARD-1:0]       board_irq,
    input  logic [N_SEC-1:0]         sec_irq_in,
    output logic [N_SEC*N_BOARD-1:0] sec_port_irq,
    output logic [N_PROC-1:0]        proc_irq
);
    import irq_route_pkg::*;

    localparam int SEC_W = N_SEC * N_BOARD;
    localparam int ALL_W = SEC_W + N_PROC;
    localparam logic [MASK_MAX-1:0] DRIVEN_FULL =
        driven_mask(N_DIRECT, FB_BASE, N_SEC, N_PROC);
    localparam logic [N_PROC-1:0] DRIVEN = DRIVEN_FULL[N_PROC-1:0];

    logic [SEC_W-1:0]  sec_comb;
    logic [N_PROC-1:0] direct_comb;
    logic [N_PROC-1:0] proc_comb;
    logic [ALL_W-1:0]  bundle_q;

    irq_fanout #(.W(N_BOARD), .PORTS(N_SEC)) u_fanout (
        .lines_in  (board_irq),
        .ports_out (sec_comb)
    );

    irq_direct_map #(.N_DIRECT(N_DIRECT), .N_PROC(N_PROC)) u_map (
        .lower_in   (board_irq[N_DIRECT-1:0]),
        .mapped_out (direct_comb)
    );

    irq_fb_merge #(.N_PROC(N_PROC), .N_SEC(N_SEC), .FB_BASE(FB_BASE)) u_merge (
        .direct_in  (direct_comb),
        .fb_in      (sec_irq_in),
        .merged_out (proc_comb)
    );

    irq_out_stage #(.W(ALL_W), .REG(REG_OUT)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sec_comb, proc_comb}),
        .q     (bundle_q)
    );

    // Split the aligned bundle back into the two output groups.
    assign sec_port_irq = bundle_q[ALL_W-1:N_PROC];
    assign proc_irq     = bundle_q[N_PROC-1:0];

    // A processor input that no source reaches never rises.
    AST_UNDRIVEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_comb & ~DRIVEN) == '0); // R6

    // Every mapped board line raises its destination.
    for (genvar i = 0; i < N_DIRECT; i++) begin : g_chk_map
        localparam int DST = direct_dst(i);
        if (DST >= 0 && DST < N_PROC) begin : g_on
            AST_MAP_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
                board_irq[i] |-> proc_comb[DST]); // R3
        end
    end

    // Every controller output raises its reserved slot.
    for (genvar n = 0; n < N_SEC; n++) begin : g_chk_fb
        AST_FB_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
            sec_irq_in[n] |-> proc_comb[FB_BASE + n]); // R5
        AST_FANOUT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
            sec_comb[n*N_BOARD +: N_BOARD] == board_irq); // R1
    end
endmodule

// File: tb/tb_irq_route_fabric.sv
`timescale 1ns/1ps
module tb_irq_route_fabric;

    typedef struct {
        logic [255:0] sec;
        logic [31:0]  proc;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [63:0]  board_irq = '0;
    logic [3:0]   sec_irq_in = '0;
    logic [255:0] sec_port_irq;
    logic [31:0]  proc_irq;

    int   checks = 0;
    int   fails  = 0;
    int   bmap [32];
    exp_t sb [$];
    bit   done = 1'b0;
    logic [31:0] last_proc = '0;

    always #2.5 clk = ~clk;

    irq_route_fabric dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .board_irq    (board_irq),
        .sec_irq_in   (sec_irq_in),
        .sec_port_irq (sec_port_irq),
        .proc_irq     (proc_irq)
    );

    task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Independent model: build the expected outputs from the requirements.
    function automatic exp_t model(input logic [63:0] b, input logic [3:0] s, input string tag);
        exp_t e;
        e.sec  = {4{b}};
        e.proc = '0;
        for (int i = 0; i < 32; i++)
            if (bmap[i] >= 0) e.proc[bmap[i]] = e.proc[bmap[i]] | b[i];
        for (int n = 0; n < 4; n++) e.proc[10+n] = e.proc[10+n] | s[n];
        e.tag = tag;
        return e;
    endfunction

    // Driver: apply stimulus at a falling edge and push the expectation.
    task automatic drive(input logic [63:0] b, input logic [3:0] s, input string tag);
        @(negedge clk);
        board_irq  = b;
        sec_irq_in = s;
        sb.push_back(model(b, s, tag));
    endtask

    // Monitor: one cycle after capture, pop and compare.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check("R1 fanout", sec_port_irq, e.sec);
            check(e.tag, {224'd0, proc_irq}, {224'd0, e.proc});
            last_proc = e.proc;
        end
    end

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) bmap[i] = -1;
        bmap[19] = 0; bmap[4]  = 1; bmap[5]  = 2; bmap[29] = 3;
        bmap[12] = 4; bmap[13] = 5; bmap[10] = 6; bmap[20] = 7;
        bmap[21] = 8; bmap[28] = 9; bmap[17] = 14; bmap[18] = 15;

        // R9: inputs all high during reset, outputs must read zero.
        board_irq  = '1;
        sec_irq_in = '1;
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset sec", sec_port_irq, '0);
        check("R9 reset proc", {224'd0, proc_irq}, '0);
        @(negedge clk);
        board_irq  = '0;
        sec_irq_in = '0;
        rst_n      = 1'b1;
        @(negedge clk);

        // Walking one over every board line.
        for (int i = 0; i < 64; i++) begin
            string tg;
            if (i >= 32)            tg = "R2 upper line";
            else if (bmap[i] >= 0)  tg = "R3 direct map";
            else                    tg = "R4 unmapped lower";
            drive(64'd1 << i, 4'd0, tg);
        end

        // Walking one over controller feedback.
        for (int n = 0; n < 4; n++) drive('0, 4'd1 << n, "R5 feedback");

        // R6: everything high, bits 16..31 must stay low.
        drive('1, 4'hF, "R6 undriven low");

        // R7: random concurrent sources.
        for (int k = 0; k < 150; k++)
            drive({$urandom, $urandom}, 4'($urandom), "R7 union");

        // R8: alternating train, plus a check that nothing moves before the edge.
        for (int k = 0; k < 8; k++) begin
            drive((k % 2 == 0) ? '1 : '0, (k % 2 == 0) ? 4'hF : 4'h0, "R8 latency");
            #1;
            check("R8 no early change", {224'd0, proc_irq}, {224'd0, last_proc});
        end

        drive('0, 4'd0, "R8 settle");
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule